// File: doc/BRIEF.md
# Floppy CHS Position and Seek Unit

This unit holds the head, track and sector at which a floppy drive is positioned. It also holds the geometry of the loaded medium and derives a linear sector index from the position. The index counts through both sides of one track before it moves on to the next track. Sectors are numbered from 1.

A seek request carries a target head, track and sector and an enable flag. The unit checks the target against the current geometry and moves only when the target is valid, differs from the present position and seeking is allowed. Each seek request produces a one-cycle done strobe with a status code. A recalibrate pulse returns the drive to head 0 and track 0.

Geometry can be loaded in two ways: with explicit values, or with a default selection that gives 18 sectors per track, 80 tracks and two sides.

Top module: `chs_seek_unit`

## Requirements
- R1: After reset the position is head 0, track 0, sector 1, `done_o` is 0 and no medium is loaded (0 sectors per track, 0 tracks, single-sided). A seek issued before any geometry load returns status 3.
- R2: `lin_idx_o` equals ((track*2)+head)*sectors_per_track + sector - 1, using the registered position and geometry.
- R3: Sector numbers start at 1: head 0, track 0, sector 1 maps to index 0. A target sector of 0 is invalid and returns status 3.
- R4: A target track equal to or above the track count returns status 3, and the position is unchanged.
- R5: A target sector above sectors_per_track returns status 3, and the position is unchanged.
- R6: A target head of 1 on single-sided media returns status 3.
- R7: A valid target whose linear index differs from the current index, requested with `seek_en_i` low, returns status 4, and the position is unchanged.
- R8: A valid, enabled seek to a different index returns status 1. Head, track and sector take the target values at the same clock edge that raises `done_o`.
- R9: A valid target whose index equals the current index returns status 0 whatever `seek_en_i` is, and the position is unchanged.
- R10: `recal_i` sets head and track to 0 and leaves the sector as it is. It takes priority over a seek request in the same cycle, and that seek is dropped with no done strobe.
- R11: `geom_load_i` stores `geom_spt_i`, `geom_trks_i` and `geom_dbl_i`. When `geom_dflt_i` is also high, it stores 18 sectors, 80 tracks and double-sided instead.
- R12: `done_o` is high for exactly one cycle after each accepted seek request. `status_o` holds the code (0 same, 1 moved, 3 invalid, 4 disabled) during that cycle and is 0 whenever `done_o` is low.
- R13: A seek issued in the same cycle as a geometry load is judged against the geometry held before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seek_req_i | input | 1 | Seek request strobe |
| seek_head_i | input | 1 | Target head |
| seek_trk_i | input | TRK_W | Target track |
| seek_sec_i | input | SEC_W | Target sector (1-based) |
| seek_en_i | input | 1 | Allow the implicit seek |
| recal_i | input | 1 | Return to head 0, track 0 |
| geom_load_i | input | 1 | Load media geometry |
| geom_dflt_i | input | 1 | Load the default geometry instead of the inputs |
| geom_spt_i | input | SEC_W | Sectors per track |
| geom_trks_i | input | TRK_W | Track count |
| geom_dbl_i | input | 1 | Double-sided medium |
| pos_head_o | output | 1 | Current head |
| pos_trk_o | output | TRK_W | Current track |
| pos_sec_o | output | SEC_W | Current sector |
| lin_idx_o | output | TRK_W+SEC_W+1 | Linear sector index |
| done_o | output | 1 | Seek result strobe |
| status_o | output | 3 | Seek status code |

## Verification
A seek request sampled at a rising edge produces its result at that same edge. `done_o`, `status_o` and the new head, track and sector are all visible in the cycle that follows, and `lin_idx_o` follows the registered position with no further delay. A recalibrate and a geometry load also take effect at the edge that samples them. The bench drives inputs on the falling edge and compares the outputs against its behavioural model at the next falling edge, which is exactly one cycle after the request. It also checks one more cycle later to confirm that the strobe has cleared.

// File: rtl/chs_pkg.sv
package chs_pkg;
  typedef enum logic [2:0] {
    ST_SAME   = 3'd0,
    ST_MOVED  = 3'd1,
    ST_RANGE  = 3'd3,
    ST_NOSEEK = 3'd4
  } seek_st_e;
endpackage

// File: rtl/chs_lin_calc.sv
module chs_lin_calc #(
  parameter int TRK_W = 8,
  parameter int SEC_W = 8,
  localparam int LIN_W = TRK_W + SEC_W + 1
) (
  input  logic             head_i,
  input  logic [TRK_W-1:0] trk_i,
  input  logic [SEC_W-1:0] sec_i,
  input  logic [SEC_W-1:0] spt_i,
  output logic [LIN_W-1:0] idx_o
);
  logic [LIN_W-1:0] cyl_side;

  // both sides of a track come before the next track
  assign cyl_side = LIN_W'({trk_i, head_i});
  assign idx_o    = cyl_side * LIN_W'(spt_i) + LIN_W'(sec_i) - LIN_W'(1);
endmodule

// File: rtl/chs_range_chk.sv
module chs_range_chk #(
  parameter int TRK_W = 8,
  parameter int SEC_W = 8
) (
  input  logic             head_i,
  input  logic [TRK_W-1:0] trk_i,
  input  logic [SEC_W-1:0] sec_i,
  input  logic [SEC_W-1:0] spt_i,
  input  logic [TRK_W-1:0] trks_i,
  input  logic             dbl_i,
  output logic             bad_o
);
  logic trk_bad, sec_bad, head_bad;

  assign trk_bad  = (trk_i >= trks_i);
  assign sec_bad  = (sec_i == '0) || (sec_i > spt_i);
  assign head_bad = head_i && !dbl_i;
  assign bad_o    = trk_bad || sec_bad || head_bad;
endmodule

// File: rtl/chs_geom_reg.sv
module chs_geom_reg #(
  parameter int TRK_W    = 8,
  parameter int SEC_W    = 8,
  parameter int DEF_SPT  = 18,
  parameter int DEF_TRKS = 80
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             dflt_i,
  input  logic [SEC_W-1:0] spt_i,
  input  logic [TRK_W-1:0] trks_i,
  input  logic             dbl_i,
  output logic [SEC_W-1:0] spt_o,
  output logic [TRK_W-1:0] trks_o,
  output logic             dbl_o
);
  localparam logic [SEC_W-1:0] DefSpt  = SEC_W'(DEF_SPT);
  localparam logic [TRK_W-1:0] DefTrks = TRK_W'(DEF_TRKS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spt_o  <= '0;
      trks_o <= '0;
      dbl_o  <= 1'b0;
    end else if (load_i) begin
      spt_o  <= dflt_i ? DefSpt  : spt_i;
      trks_o <= dflt_i ? DefTrks : trks_i;
      dbl_o  <= dflt_i ? 1'b1    : dbl_i;
    end
  end
endmodule

// File: rtl/chs_seek_unit.sv
module chs_seek_unit #(
  parameter int TRK_W    = 8,
  parameter int SEC_W    = 8,
  parameter int DEF_SPT  = 18,
  parameter int DEF_TRKS = 80,
  localparam int LIN_W   = TRK_W + SEC_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seek_req_i,
  input  logic             seek_head_i,
  input  logic [TRK_W-1:0] seek_trk_i,
  input  logic [SEC_W-1:0] seek_sec_i,
  input  logic             seek_en_i,
  input  logic             recal_i,
  input  logic             geom_load_i,
  input  logic             geom_dflt_i,
  input  logic [SEC_W-1:0] geom_spt_i,
  input  logic [TRK_W-1:0] geom_trks_i,
  input  logic             geom_dbl_i,
  output logic             pos_head_o,
  output logic [TRK_W-1:0] pos_trk_o,
  output logic [SEC_W-1:0] pos_sec_o,
  output logic [LIN_W-1:0] lin_idx_o,
  output logic             done_o,
  output logic [2:0]       status_o
);
  import chs_pkg::*;

  logic [SEC_W-1:0] spt_q;
  logic [TRK_W-1:0] trks_q;
  logic             dbl_q;
  logic             head_q;
  logic [TRK_W-1:0] trk_q;
  logic [SEC_W-1:0] sec_q;
  logic             done_q;
  seek_st_e         st_q;
  logic [LIN_W-1:0] cur_idx, tgt_idx;
  logic             tgt_bad;

  chs_geom_reg #(
    .TRK_W(TRK_W), .SEC_W(SEC_W), .DEF_SPT(DEF_SPT), .DEF_TRKS(DEF_TRKS)
  ) i_geom (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(geom_load_i), .dflt_i(geom_dflt_i),
    .spt_i(geom_spt_i), .trks_i(geom_trks_i), .dbl_i(geom_dbl_i),
    .spt_o(spt_q), .trks_o(trks_q), .dbl_o(dbl_q)
  );

  chs_range_chk #(.TRK_W(TRK_W), .SEC_W(SEC_W)) i_range (
    .head_i(seek_head_i), .trk_i(seek_trk_i), .sec_i(seek_sec_i),
    .spt_i(spt_q), .trks_i(trks_q), .dbl_i(dbl_q), .bad_o(tgt_bad)
  );

  chs_lin_calc #(.TRK_W(TRK_W), .SEC_W(SEC_W)) i_cur_idx (
    .head_i(head_q), .trk_i(trk_q), .sec_i(sec_q), .spt_i(spt_q), .idx_o(cur_idx)
  );

  chs_lin_calc #(.TRK_W(TRK_W), .SEC_W(SEC_W)) i_tgt_idx (
    .head_i(seek_head_i), .trk_i(seek_trk_i), .sec_i(seek_sec_i), .spt_i(spt_q),
    .idx_o(tgt_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= 1'b0;
      trk_q  <= '0;
      sec_q  <= SEC_W'(1);
      done_q <= 1'b0;
      st_q   <= ST_SAME;
    end else begin
      done_q <= 1'b0;
      st_q   <= ST_SAME;
      if (recal_i) begin
        head_q <= 1'b0;
        trk_q  <= '0;
      end else if (seek_req_i) begin
        done_q <= 1'b1;
        if (tgt_bad) begin
          st_q <= ST_RANGE;
        end else if (tgt_idx == cur_idx) begin
          st_q <= ST_SAME;
        end else if (!seek_en_i) begin
          st_q <= ST_NOSEEK;
        end else begin
          st_q   <= ST_MOVED;
          head_q <= seek_head_i;
          trk_q  <= seek_trk_i;
          sec_q  <= seek_sec_i;
        end
      end
    end
  end

  assign pos_head_o = head_q;
  assign pos_trk_o  = trk_q;
  assign pos_sec_o  = sec_q;
  assign lin_idx_o  = cur_idx;
  assign done_o     = done_q;
  assign status_o   = st_q;
endmodule

// File: rtl/chs_seek_unit_chk.sv
module chs_seek_unit_chk #(
  parameter int TRK_W = 8,
  parameter int SEC_W = 8,
  localparam int LIN_W = TRK_W + SEC_W + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             seek_req_i,
  input logic             recal_i,
  input logic             pos_head_o,
  input logic [TRK_W-1:0] pos_trk_o,
  input logic [SEC_W-1:0] pos_sec_o,
  input logic [LIN_W-1:0] lin_idx_o,
  input logic             done_o,
  input logic [2:0]       status_o
);
  a_r12_done_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seek_req_i && !recal_i) |=> done_o);

  a_r12_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(seek_req_i && !recal_i) |=> !done_o);

  a_r12_status_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> status_o == 3'd0);

  a_r12_status_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (status_o == 3'd0 || status_o == 3'd1 || status_o == 3'd3 || status_o == 3'd4));

  a_r10_recal_home: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recal_i |=> (!pos_head_o && pos_trk_o == '0));

  a_r10_recal_keeps_sec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recal_i |=> $stable(pos_sec_o));

  a_r4_hold_on_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (status_o == 3'd3 || status_o == 3'd4)) |-> $stable({pos_head_o, pos_trk_o, pos_sec_o}));

  a_r9_same_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == 3'd0) |-> $stable({pos_head_o, pos_trk_o, pos_sec_o}));

  a_r8_move_changes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == 3'd1) |-> !$stable({pos_head_o, pos_trk_o, pos_sec_o}));

  a_r3_sector_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_sec_o != '0);
endmodule

bind chs_seek_unit chs_seek_unit_chk #(.TRK_W(TRK_W), .SEC_W(SEC_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .seek_req_i(seek_req_i), .recal_i(recal_i),
  .pos_head_o(pos_head_o), .pos_trk_o(pos_trk_o), .pos_sec_o(pos_sec_o),
  .lin_idx_o(lin_idx_o), .done_o(done_o), .status_o(status_o)
);

// File: tb/test_chs_seek_unit.sv
module test_chs_seek_unit;
  localparam int TRK_W = 8;
  localparam int SEC_W = 8;
  localparam int LIN_W = TRK_W + SEC_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seek_req = 1'b0, seek_head = 1'b0, seek_en = 1'b0, recal = 1'b0;
  logic [TRK_W-1:0] seek_trk = '0;
  logic [SEC_W-1:0] seek_sec = '0;
  logic geom_load = 1'b0, geom_dflt = 1'b0, geom_dbl = 1'b0;
  logic [SEC_W-1:0] geom_spt = '0;
  logic [TRK_W-1:0] geom_trks = '0;
  logic pos_head, done;
  logic [TRK_W-1:0] pos_trk;
  logic [SEC_W-1:0] pos_sec;
  logic [LIN_W-1:0] lin_idx;
  logic [2:0] status;

  int checks = 0, errors = 0;
  bit finished = 0;
  string cur_req = "R1";

  // behavioural reference
  int m_head, m_trk, m_sec, m_spt, m_trks, m_dbl, m_done, m_st;

  always #10 clk = ~clk;

  chs_seek_unit i_chs_seek_unit (
    .clk_i(clk), .rst_ni(rst_n), .seek_req_i(seek_req), .seek_head_i(seek_head),
    .seek_trk_i(seek_trk), .seek_sec_i(seek_sec), .seek_en_i(seek_en), .recal_i(recal),
    .geom_load_i(geom_load), .geom_dflt_i(geom_dflt), .geom_spt_i(geom_spt),
    .geom_trks_i(geom_trks), .geom_dbl_i(geom_dbl), .pos_head_o(pos_head),
    .pos_trk_o(pos_trk), .pos_sec_o(pos_sec), .lin_idx_o(lin_idx), .done_o(done),
    .status_o(status)
  );

  function automatic int lin(int h, int t, int s, int spt);
    return (((t * 2 + h) * spt) + s - 1) & ((1 << LIN_W) - 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_head = 0; m_trk = 0; m_sec = 1; m_spt = 0; m_trks = 0; m_dbl = 0;
      m_done = 0; m_st = 0;
    end else begin
      int h, t, s;
      bit bad;
      h = seek_head; t = seek_trk; s = seek_sec;
      m_done = 0; m_st = 0;
      if (recal) begin
        m_head = 0; m_trk = 0;
      end else if (seek_req) begin
        m_done = 1;
        bad = (t >= m_trks) || (s == 0) || (s > m_spt) || (h == 1 && m_dbl == 0);
        if (bad) m_st = 3;
        else if (lin(h, t, s, m_spt) == lin(m_head, m_trk, m_sec, m_spt)) m_st = 0;
        else if (!seek_en) m_st = 4;
        else begin m_st = 1; m_head = h; m_trk = t; m_sec = s; end
      end
      if (geom_load) begin
        if (geom_dflt) begin m_spt = 18; m_trks = 80; m_dbl = 1; end
        else begin m_spt = geom_spt; m_trks = geom_trks; m_dbl = geom_dbl; end
      end
    end
  end

  task automatic chk(string what, int act, int exp, string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // compare against model every cycle
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("head", int'(pos_head), m_head, cur_req);
      chk("track", int'(pos_trk), m_trk, cur_req);
      chk("sector", int'(pos_sec), m_sec, cur_req);
      chk("index", int'(lin_idx), lin(m_head, m_trk, m_sec, m_spt), cur_req);
      chk("done", int'(done), m_done, cur_req);
      chk("status", int'(status), m_st, cur_req);
    end
  end

  task automatic seek(int h, int t, int s, bit en);
    @(negedge clk);
    seek_req = 1'b1; seek_head = h[0]; seek_trk = t[TRK_W-1:0];
    seek_sec = s[SEC_W-1:0]; seek_en = en;
    @(negedge clk);
    seek_req = 1'b0;
  endtask

  task automatic load(bit dflt, int spt, int trks, bit dbl);
    @(negedge clk);
    geom_load = 1'b1; geom_dflt = dflt; geom_spt = spt[SEC_W-1:0];
    geom_trks = trks[TRK_W-1:0]; geom_dbl = dbl;
    @(negedge clk);
    geom_load = 1'b0; geom_dflt = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    chk("reset head", int'(pos_head), 0, "R1");
    chk("reset track", int'(pos_trk), 0, "R1");
    chk("reset sector", int'(pos_sec), 1, "R1");
    chk("reset done", int'(done), 0, "R1");
    seek(0, 0, 1, 1);
    chk("no media status", int'(status), 3, "R1");

    cur_req = "R11";
    load(1, 0, 0, 0);
    cur_req = "R8";
    seek(1, 79, 18, 1);
    chk("move status", int'(status), 1, "R8");
    chk("move track", int'(pos_trk), 79, "R8");
    chk("default geometry index", int'(lin_idx), 2879, "R11");

    cur_req = "R12";
    @(negedge clk);
    chk("done cleared", int'(done), 0, "R12");
    chk("status cleared", int'(status), 0, "R12");

    cur_req = "R9";
    seek(1, 79, 18, 1);
    chk("same enabled", int'(status), 0, "R9");
    seek(1, 79, 18, 0);
    chk("same disabled", int'(status), 0, "R9");

    cur_req = "R4";
    seek(0, 80, 1, 1);
    chk("track range", int'(status), 3, "R4");
    chk("track held", int'(pos_trk), 79, "R4");

    cur_req = "R5";
    seek(0, 5, 19, 1);
    chk("sector range", int'(status), 3, "R5");
    cur_req = "R3";
    seek(0, 5, 0, 1);
    chk("sector zero", int'(status), 3, "R3");

    cur_req = "R7";
    seek(0, 0, 1, 0);
    chk("disabled status", int'(status), 4, "R7");
    chk("disabled held", int'(pos_sec), 18, "R7");

    cur_req = "R3";
    seek(0, 0, 1, 1);
    chk("origin index", int'(lin_idx), 0, "R3");

    cur_req = "R11";
    load(0, 9, 40, 0);
    cur_req = "R6";
    seek(1, 3, 2, 1);
    chk("single-sided head", int'(status), 3, "R6");
    cur_req = "R2";
    seek(0, 39, 9, 1);
    chk("explicit geometry index", int'(lin_idx), 710, "R2");

    cur_req = "R10";
    @(negedge clk); recal = 1'b1;
    @(negedge clk); recal = 1'b0;
    chk("recal track", int'(pos_trk), 0, "R10");
    chk("recal sector kept", int'(pos_sec), 9, "R10");
    @(negedge clk);
    recal = 1'b1; seek_req = 1'b1; seek_head = 1'b0; seek_trk = 8'd7; seek_sec = 8'd3; seek_en = 1'b1;
    @(negedge clk);
    recal = 1'b0; seek_req = 1'b0;
    chk("recal drops seek", int'(done), 0, "R10");
    chk("recal drops seek track", int'(pos_trk), 0, "R10");

    cur_req = "R13";
    @(negedge clk);
    geom_load = 1'b1; geom_dflt = 1'b1;
    seek_req = 1'b1; seek_head = 1'b1; seek_trk = 8'd50; seek_sec = 8'd10; seek_en = 1'b1;
    @(negedge clk);
    geom_load = 1'b0; geom_dflt = 1'b0; seek_req = 1'b0;
    chk("old geometry used", int'(status), 3, "R13");
    seek(1, 50, 10, 1);
    chk("new geometry used", int'(status), 1, "R13");

    cur_req = "R2";
    for (int i = 0; i < 300; i++) begin
      if (i % 60 == 0) load($urandom_range(1, 0), $urandom_range(30, 1), $urandom_range(100, 1), $urandom_range(1, 0));
      if (i % 37 == 5) begin
        @(negedge clk); recal = 1'b1;
        @(negedge clk); recal = 1'b0;
      end
      seek($urandom_range(1, 0), $urandom_range(110, 0), $urandom_range(32, 0), $urandom_range(1, 0));
    end

    @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule